// File: doc/BRIEF.md
# Sixteen-Entry Register File with Constant Generator

This block holds the sixteen 16-bit working registers of a small 16-bit processor core. It has two combinational read ports and one clocked write port. Index 0 holds the program counter and index 1 holds the stack pointer. Both are ordinary registers that any write may target, but bit 0 of each is kept at zero. Indices 2 and 3 also act as a constant source. Each read port carries a 2-bit source addressing mode alongside its register index. For certain mode values, a read of register 2 or register 3 returns a fixed small number instead of the stored contents. This lets the core use frequent immediates without fetching an extra operand word.

The write port takes a width select and a keep flag. A byte-wide write loads the low byte and zeroes the upper byte of the destination. Instructions that only compare or test their destination set the keep flag, and the register is then left untouched. Reads are combinational from the stored state. A register written on a clock edge shows its new value only after that edge, so a read in the same cycle as the write returns the old contents.

Top module: `regfile_cg`

## Requirements
- R1: While reset is asserted and after it is released, every register reads as 0000h in mode 00.
- R2: A word write (enable=1, keep=0, byte=0) to registers 2 to 15 stores all 16 data bits. The new value appears on the read ports only after the rising edge that performs the write; a same-cycle read returns the previous value.
- R3: Any write to register 0 or register 1 stores bit 0 as zero, for both word and byte writes; the other bits follow the normal write rules.
- R4: A read of register 3 returns a constant chosen by mode, whatever has been written to it: mode 00 gives 0000h, 01 gives 0001h, 10 gives 0002h and 11 gives FFFFh.
- R5: A read of register 2 returns its stored contents in mode 00, 0000h in mode 01, 0004h in mode 10 and 0008h in mode 11.
- R6: A read of any register other than 2 and 3 returns the stored contents in every mode.
- R7: A byte write (byte=1) stores data bits 7:0 into the low byte and zero into bits 15:8.
- R8: When enable is 0, or when keep is 1, no register changes on the clock edge.
- R9: The two read ports work independently and in the same cycle, each with its own index and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes take effect on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; clears all registers |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_mode_i | input | 2 | Read port A source addressing mode |
| rd_a_data_o | output | 16 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_mode_i | input | 2 | Read port B source addressing mode |
| rd_b_data_o | output | 16 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_keep_i | input | 1 | Destination is not modified (compare, test, bit-test, byte push) |
| wr_byte_i | input | 1 | 1 = byte write, 0 = word write |
| wr_idx_i | input | 4 | Write register index |
| wr_data_i | input | 16 | Write data |

## Verification
The state that is hardest to observe is the stored contents of register 3, and of register 2 behind its constant modes. These contents never reach the ports except through register 2 in mode 00. The bench therefore writes all-ones and odd patterns into both registers. It then sweeps every mode on both ports to show that the constants win, and returns register 2 to mode 00 to confirm that the write did land there. The forced-even rule is reached by writing odd values, word and byte, into registers 0 and 1. A long random phase then mixes keep, disabled writes and same-cycle read-after-write on both ports, all checked against a behavioural model.

// File: rtl/regfile_cg_pkg.sv
package regfile_cg_pkg;
  localparam int PC_IDX = 0;
  localparam int SP_IDX = 1;
  localparam int SR_IDX = 2;
  localparam int CG_IDX = 3;

  typedef enum logic [1:0] {
    MODE_REG = 2'b00,
    MODE_OFS = 2'b01,
    MODE_IND = 2'b10,
    MODE_INC = 2'b11
  } src_mode_e;
endpackage

// File: rtl/rf_wr_fmt.sv
module rf_wr_fmt
  import regfile_cg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              en_i,
  input  logic              keep_i,
  input  logic              byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  widx_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int HI_W = DATA_W - 8;

  logic             force_even;
  logic [DATA_W-1:0] sized;

  assign we_o   = en_i & ~keep_i;
  assign widx_o = idx_i;

  // byte writes clear the upper part of the destination
  assign sized = byte_i ? {{HI_W{1'b0}}, data_i[7:0]} : data_i;

  assign force_even = (idx_i == PC_IDX[IDX_W-1:0]) || (idx_i == SP_IDX[IDX_W-1:0]);

  always_comb begin
    wdata_o = sized;
    if (force_even) wdata_o[0] = 1'b0;
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import regfile_cg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [IDX_W-1:0]                   widx_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (we_i && widx_i == IDX_W'(g))        q <= wdata_i;
    end
    assign regs_o[g] = q;
  end

  // R3
  pc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[PC_IDX][0] == 1'b0);
  // R3
  sp_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[SP_IDX][0] == 1'b0);
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import regfile_cg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [1:0]                      mode_i,
  output logic [DATA_W-1:0]               data_o
);
  logic is_sr, is_cg;
  src_mode_e mode;

  assign mode  = src_mode_e'(mode_i);
  assign is_sr = (idx_i == SR_IDX[IDX_W-1:0]);
  assign is_cg = (idx_i == CG_IDX[IDX_W-1:0]);

  // constants are muxed in place of the stored word: same path depth
  always_comb begin
    data_o = regs_i[idx_i];
    if (is_cg) begin
      unique case (mode)
        MODE_REG: data_o = '0;
        MODE_OFS: data_o = DATA_W'(1);
        MODE_IND: data_o = DATA_W'(2);
        MODE_INC: data_o = '1;
      endcase
    end else if (is_sr) begin
      unique case (mode)
        MODE_REG: data_o = regs_i[idx_i];
        MODE_OFS: data_o = '0;
        MODE_IND: data_o = DATA_W'(4);
        MODE_INC: data_o = DATA_W'(8);
      endcase
    end
  end

  // R4
  cg_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cg && mode_i == 2'b11) |-> data_o == {DATA_W{1'b1}});
  // R5
  sr_four_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sr && mode_i == 2'b10) |-> data_o == DATA_W'(4));
  // R6
  plain_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_sr && !is_cg) |-> data_o == regs_i[idx_i]);
endmodule

// File: rtl/regfile_cg.sv
module regfile_cg
  import regfile_cg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [$clog2(NUM_REGS)-1:0] rd_a_idx_i,
  input  logic [1:0]                  rd_a_mode_i,
  output logic [DATA_W-1:0]           rd_a_data_o,
  input  logic [$clog2(NUM_REGS)-1:0] rd_b_idx_i,
  input  logic [1:0]                  rd_b_mode_i,
  output logic [DATA_W-1:0]           rd_b_data_o,
  input  logic                        wr_en_i,
  input  logic                        wr_keep_i,
  input  logic                        wr_byte_i,
  input  logic [$clog2(NUM_REGS)-1:0] wr_idx_i,
  input  logic [DATA_W-1:0]           wr_data_i
);
  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int NUM_RD = 2;

  logic                            we;
  logic [IDX_W-1:0]                widx;
  logic [DATA_W-1:0]               wdata;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
  logic [NUM_RD-1:0][1:0]          rd_mode;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  rf_wr_fmt #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wr_fmt (
    .en_i   (wr_en_i),
    .keep_i (wr_keep_i),
    .byte_i (wr_byte_i),
    .idx_i  (wr_idx_i),
    .data_i (wr_data_i),
    .we_o   (we),
    .widx_o (widx),
    .wdata_o(wdata)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_storage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .widx_i (widx),
    .wdata_i(wdata),
    .regs_o (regs)
  );

  assign rd_idx  = {rd_b_idx_i, rd_a_idx_i};
  assign rd_mode = {rd_b_mode_i, rd_a_mode_i};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .regs_i(regs),
      .idx_i (rd_idx[p]),
      .mode_i(rd_mode[p]),
      .data_o(rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || wr_keep_i) |=> $stable(regs));
  // R7
  byte_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_keep_i && wr_byte_i) |=> regs[$past(wr_idx_i)][DATA_W-1:8] == '0);
  // R2
  word_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_keep_i && !wr_byte_i && wr_idx_i > IDX_W'(SP_IDX))
    |=> regs[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: tb/regfile_cg_tb.sv
module regfile_cg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  a_idx = '0, b_idx = '0, w_idx = '0;
  logic [1:0]  a_mode = '0, b_mode = '0;
  logic [15:0] a_data, b_data, w_data = '0;
  logic        w_en = 1'b0, w_keep = 1'b0, w_byte = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model [16];

  always #5 clk = ~clk;

  regfile_cg u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(a_idx), .rd_a_mode_i(a_mode), .rd_a_data_o(a_data),
    .rd_b_idx_i(b_idx), .rd_b_mode_i(b_mode), .rd_b_data_o(b_data),
    .wr_en_i(w_en), .wr_keep_i(w_keep), .wr_byte_i(w_byte),
    .wr_idx_i(w_idx), .wr_data_i(w_data)
  );

  function automatic logic [15:0] exp_rd(int idx, logic [1:0] m);
    if (idx == 3) begin
      case (m)
        2'b00: return 16'h0000;
        2'b01: return 16'h0001;
        2'b10: return 16'h0002;
        default: return 16'hFFFF;
      endcase
    end
    if (idx == 2) begin
      case (m)
        2'b00: return model[2];
        2'b01: return 16'h0000;
        2'b10: return 16'h0004;
        default: return 16'h0008;
      endcase
    end
    return model[idx];
  endfunction

  task automatic check(string tag, string port, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  task automatic step(bit en, bit keep, bit byt, int wi, logic [15:0] wd,
                      int ai, logic [1:0] am, int bi, logic [1:0] bm, string tag);
    logic [15:0] v;
    @(negedge clk);
    w_en = en; w_keep = keep; w_byte = byt; w_idx = 4'(wi); w_data = wd;
    a_idx = 4'(ai); a_mode = am; b_idx = 4'(bi); b_mode = bm;
    #1;
    check(tag, "A", a_data, exp_rd(ai, am));
    check(tag, "B", b_data, exp_rd(bi, bm));
    @(posedge clk);
    if (rst_n && en && !keep) begin
      v = byt ? {8'h00, wd[7:0]} : wd;
      if (wi <= 1) v[0] = 1'b0;
      model[wi] = v;
    end
  endtask

  task automatic rd(int ai, logic [1:0] am, int bi, logic [1:0] bm, string tag);
    step(1'b0, 1'b0, 1'b0, 0, 16'h0, ai, am, bi, bm, tag);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 16'h0;
    // R1: outputs during reset
    #1;
    check("R1", "A", a_data, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) rd(i, 2'b00, 15 - i, 2'b00, "R1");

    // R2: word write, same-cycle read returns old value
    step(1'b1, 1'b0, 1'b0, 5, 16'h1234, 5, 2'b00, 5, 2'b01, "R2");
    rd(5, 2'b00, 5, 2'b11, "R2");
    step(1'b1, 1'b0, 1'b0, 15, 16'hBEEF, 15, 2'b00, 5, 2'b00, "R2");
    rd(15, 2'b10, 15, 2'b00, "R2");

    // R3: PC/SP stay even
    step(1'b1, 1'b0, 1'b0, 0, 16'hABCD, 0, 2'b00, 1, 2'b00, "R3");
    step(1'b1, 1'b0, 1'b0, 1, 16'h0003, 0, 2'b00, 1, 2'b00, "R3");
    step(1'b1, 1'b0, 1'b1, 1, 16'hFF55, 0, 2'b00, 1, 2'b00, "R3");
    rd(0, 2'b00, 1, 2'b00, "R3");

    // R4: constants on index 3 regardless of stored value
    for (int m = 0; m < 4; m++) rd(3, 2'(m), 3, 2'(3 - m), "R4");
    step(1'b1, 1'b0, 1'b0, 3, 16'hFFFF, 3, 2'b00, 3, 2'b01, "R4");
    for (int m = 0; m < 4; m++) rd(3, 2'(m), 3, 2'(m), "R4");

    // R5: index 2 modes
    step(1'b1, 1'b0, 1'b0, 2, 16'h1235, 2, 2'b00, 2, 2'b11, "R5");
    for (int m = 0; m < 4; m++) rd(2, 2'(m), 2, 2'(3 - m), "R5");

    // R6: other registers ignore mode
    step(1'b1, 1'b0, 1'b0, 7, 16'h8001, 7, 2'b00, 0, 2'b11, "R6");
    for (int m = 0; m < 4; m++) rd(7, 2'(m), 0, 2'(m), "R6");

    // R7: byte write clears upper byte
    step(1'b1, 1'b0, 1'b0, 9, 16'hFFFF, 9, 2'b00, 9, 2'b00, "R7");
    step(1'b1, 1'b0, 1'b1, 9, 16'hA5C3, 9, 2'b00, 9, 2'b00, "R7");
    step(1'b1, 1'b0, 1'b1, 2, 16'h7781, 9, 2'b00, 2, 2'b00, "R7");
    rd(9, 2'b00, 2, 2'b00, "R7");

    // R8: keep and disabled writes leave registers alone
    step(1'b1, 1'b1, 1'b1, 9, 16'h0000, 9, 2'b00, 9, 2'b00, "R8");
    step(1'b1, 1'b1, 1'b0, 5, 16'h0000, 5, 2'b00, 9, 2'b00, "R8");
    step(1'b0, 1'b0, 1'b0, 15, 16'h0000, 15, 2'b00, 5, 2'b00, "R8");
    rd(15, 2'b00, 5, 2'b00, "R8");
    rd(9, 2'b01, 9, 2'b10, "R8");

    // R9: random mix on both ports
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom;
      step(r[0] | r[1], r[2] & r[3], r[4], int'(r[8:5]), 16'($urandom),
           int'(r[12:9]), r[14:13], int'(r[18:15]), r[20:19], "R9");
    end

    finish_run();
  end
endmodule